// File: doc/BRIEF.md
# Lane Event Counter

This block is a single event counter that software programs through a small register interface. Hardware presents a flat vector of one-cycle event strobes, one strobe per event code and per lane. Software writes a control word naming a group, an event within that group and a lane. It then issues commands through two small command fields to start, stop or zero the count, and it reads the running total from a separate read-only data register.

The selected strobe is sampled on every clock. While counting is on, each cycle in which that strobe is high adds one to the count. Choosing a new event leaves the count as it was, so software zeroes it with the clear command before a fresh measurement. Event codes, lanes or groups beyond the configured sizes select nothing.

Top module: `lane_evt_counter`

## Requirements
- R1: After reset the count is 0, counting is off, and the control register reads 0.
- R2: A write to the control register at offset 0x8 stores the group number from bits 27:24, the event number from bits 23:16 and the lane index from bits 11:8. These fields read back in the same positions, and the command fields in bits 4:0 read as 0.
- R3: Writing 3 to the start/stop field (bits 4:2) turns counting on and writing 1 turns it off. Bit 7 of the control register reads 1 while counting is on and 0 otherwise.
- R4: Any other value in the start/stop field leaves the on/off state unchanged.
- R5: The value 1 in the zeroing field (bits 1:0) sets the count to 0, and this takes priority over an event in the same cycle. Any other value leaves the count unchanged.
- R6: While counting is on, the count rises by exactly one on each clock in which the selected strobe is high. The strobe for group g, event e and lane l is bit ((g*EVTS_PER_GROUP + e)*NUM_LANES + l) of the event vector. Strobes of other lanes, events or groups do not count.
- R7: A lane index of NUM_LANES or more, an event number of EVTS_PER_GROUP or more, or a group number of NUM_GROUPS or more selects no strobe.
- R8: Changing the selected event does not change the count.
- R9: The count wraps to 0 after reaching 2^CNT_W - 1 (CNT_W is 32 by default).
- R10: The data register at offset 0xC returns the count, zero-extended. Writes to it are ignored, and reads of any other offset return 0.
- R11: Read data appears on the clock edge at which the read request is sampled and shows the values held just before that edge. It holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| evt_i | input | NUM_GROUPS*EVTS_PER_GROUP*NUM_LANES | Event strobes, lane index fastest |

## Verification
A control write changes the on/off state, the selection and the zeroing on the edge that samples it. An event strobe adds to the count on the edge where it is high. A read shows the count as it stood before the edge that samples the request. The bench drives every input just after a falling edge and holds it for one full cycle. It reads the result at the next falling edge, so each expected value counts exactly the rising edges that saw the strobe high. A second instance with an 8-bit count shares the same inputs and shows the wrap after 259 events.

// File: rtl/lec_pkg.sv
`timescale 1ns/1ps
package lec_pkg;
  // control word field positions (software decodes these)
  localparam int GRP_LO  = 24;
  localparam int EVT_LO  = 16;
  localparam int LANE_LO = 8;
  localparam int STAT_B  = 7;
  localparam int RUN_LO  = 2;

  localparam logic [2:0] RUN_CMD_START = 3'd3;
  localparam logic [2:0] RUN_CMD_STOP  = 3'd1;
  localparam logic [1:0] ZERO_CMD      = 2'd1;

  typedef struct packed {
    logic [3:0] grp;
    logic [7:0] evt;
    logic [3:0] lane;
  } sel_t;
endpackage

// File: rtl/lec_ctrl.sv
`timescale 1ns/1ps
module lec_ctrl
  import lec_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_ctrl,
  input  logic [31:0] wdata,
  output sel_t        sel_q,
  output logic        run_q,
  output logic        zero_req
);
  logic [2:0] run_cmd;
  logic [1:0] zero_cmd;
  logic       unused_wbits;

  assign run_cmd      = wdata[RUN_LO +: 3];
  assign zero_cmd     = wdata[1:0];
  assign zero_req     = wr_ctrl && (zero_cmd == ZERO_CMD);
  assign unused_wbits = ^{wdata[31:28], wdata[15:12], wdata[7:5]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      run_q <= 1'b0;
    end else if (wr_ctrl) begin
      sel_q.grp  <= wdata[GRP_LO +: 4];
      sel_q.evt  <= wdata[EVT_LO +: 8];
      sel_q.lane <= wdata[LANE_LO +: 4];
      case (run_cmd)
        RUN_CMD_START: run_q <= 1'b1;
        RUN_CMD_STOP:  run_q <= 1'b0;
        default:       run_q <= run_q;
      endcase
    end
  end
endmodule

// File: rtl/lec_evt_mux.sv
`timescale 1ns/1ps
module lec_evt_mux
  import lec_pkg::*;
#(
  parameter int NUM_GROUPS     = 8,
  parameter int EVTS_PER_GROUP = 20,
  parameter int NUM_LANES      = 4,
  localparam int NUM_CODES     = NUM_GROUPS * EVTS_PER_GROUP,
  localparam int NUM_EVT       = NUM_CODES * NUM_LANES
) (
  input  logic [NUM_EVT-1:0] evt_i,
  input  sel_t               sel,
  output logic               hit
);
  localparam int CODE_W = (NUM_CODES > 1) ? $clog2(NUM_CODES) : 1;
  localparam int LIW    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

  logic [NUM_LANES-1:0] by_code [NUM_CODES];

  for (genvar c = 0; c < NUM_CODES; c++) begin : g_code
    assign by_code[c] = evt_i[c*NUM_LANES +: NUM_LANES];
  end

  logic              code_ok;
  logic [CODE_W-1:0] code_idx;
  logic [LIW-1:0]    lane_idx;

  always_comb begin
    code_ok  = ({1'b0, sel.grp}  < 5'(NUM_GROUPS)) &&
               ({1'b0, sel.evt}  < 9'(EVTS_PER_GROUP)) &&
               ({1'b0, sel.lane} < 5'(NUM_LANES));
    code_idx = code_ok ? CODE_W'(32'(sel.grp) * 32'(EVTS_PER_GROUP) + 32'(sel.evt))
                       : '0;
    lane_idx = code_ok ? LIW'(sel.lane) : '0;
    hit      = code_ok && by_code[code_idx][lane_idx];
  end
endmodule

// File: rtl/lec_count.sv
`timescale 1ns/1ps
module lec_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             zero_req,
  input  logic             run,
  input  logic             hit,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst || zero_req) cnt_q <= '0;
    else if (run && hit) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lane_evt_counter.sv
`timescale 1ns/1ps
module lane_evt_counter
  import lec_pkg::*;
#(
  parameter int              NUM_GROUPS     = 8,
  parameter int              EVTS_PER_GROUP = 20,
  parameter int              NUM_LANES      = 4,
  parameter int              CNT_W          = 32,
  parameter int              ADDR_W         = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS     = 'h8,
  parameter logic [ADDR_W-1:0] DATA_OFS     = 'hC,
  localparam int             NUM_EVT        = NUM_GROUPS * EVTS_PER_GROUP * NUM_LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [NUM_EVT-1:0] evt_i
);
  sel_t             sel_q;
  logic             run_q;
  logic             zero_req;
  logic             evt_hit;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_ctrl;
  logic [31:0]      ctrl_word;

  assign wr_ctrl = reg_wr_i && (reg_addr_i == CTRL_OFS);

  lec_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wdata(reg_wdata_i),
    .sel_q(sel_q), .run_q(run_q), .zero_req(zero_req)
  );

  lec_evt_mux #(
    .NUM_GROUPS(NUM_GROUPS), .EVTS_PER_GROUP(EVTS_PER_GROUP), .NUM_LANES(NUM_LANES)
  ) u_mux (
    .evt_i(evt_i), .sel(sel_q), .hit(evt_hit)
  );

  lec_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .zero_req(zero_req), .run(run_q),
    .hit(evt_hit), .cnt_q(cnt_q)
  );

  always_comb begin
    ctrl_word                  = '0;
    ctrl_word[GRP_LO +: 4]     = sel_q.grp;
    ctrl_word[EVT_LO +: 8]     = sel_q.evt;
    ctrl_word[LANE_LO +: 4]    = sel_q.lane;
    ctrl_word[STAT_B]          = run_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata_o <= '0;
    end else if (reg_rd_i) begin
      if (reg_addr_i == CTRL_OFS)      reg_rdata_o <= ctrl_word;
      else if (reg_addr_i == DATA_OFS) reg_rdata_o <= 32'(cnt_q);
      else                             reg_rdata_o <= '0;
    end
  end
endmodule

// File: rtl/lec_checker.sv
`timescale 1ns/1ps
module lec_checker #(
  parameter int                ADDR_W    = 8,
  parameter int                CNT_W     = 32,
  parameter int                NUM_LANES = 4,
  parameter logic [ADDR_W-1:0] CTRL_OFS  = 'h8,
  parameter logic [ADDR_W-1:0] DATA_OFS  = 'hC
) (
  input logic              clk,
  input logic              rst,
  input logic              wr,
  input logic              rd,
  input logic [ADDR_W-1:0] addr,
  input logic [4:0]        wcmd,
  input logic [31:0]       rdata,
  input logic              run,
  input logic              hit,
  input logic [3:0]        lane,
  input logic [CNT_W-1:0]  cnt
);
  logic wctl, zero;
  assign wctl = wr && (addr == CTRL_OFS);
  assign zero = wctl && (wcmd[1:0] == 2'd1);

  assert_start_R3: assert property (@(posedge clk) disable iff (rst)
    wctl && (wcmd[4:2] == 3'd3) |=> run);
  assert_stop_R3: assert property (@(posedge clk) disable iff (rst)
    wctl && (wcmd[4:2] == 3'd1) |=> !run);
  assert_keep_run_R4: assert property (@(posedge clk) disable iff (rst)
    !(wctl && (wcmd[4:2] == 3'd3 || wcmd[4:2] == 3'd1)) |=> $stable(run));
  assert_zero_R5: assert property (@(posedge clk) disable iff (rst)
    zero |=> cnt == '0);
  assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !run && !zero |=> $stable(cnt));
  assert_step_R6: assert property (@(posedge clk) disable iff (rst)
    !zero |=> (cnt == $past(cnt)) || (cnt == CNT_W'($past(cnt) + 1'b1)));
  assert_lane_R7: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, lane} >= 5'(NUM_LANES)) |-> !hit);
  assert_read_R10: assert property (@(posedge clk) disable iff (rst)
    rd && (addr == DATA_OFS) |=> rdata == 32'($past(cnt)));
endmodule

bind lane_evt_counter lec_checker #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_LANES(NUM_LANES),
  .CTRL_OFS(CTRL_OFS), .DATA_OFS(DATA_OFS)
) u_lec_chk (
  .clk(clk), .rst(rst), .wr(reg_wr_i), .rd(reg_rd_i), .addr(reg_addr_i),
  .wcmd(reg_wdata_i[4:0]), .rdata(reg_rdata_o), .run(run_q), .hit(evt_hit),
  .lane(sel_q.lane), .cnt(cnt_q)
);

// File: tb/tb_lane_evt_counter.sv
`timescale 1ns/1ps
module tb_lane_evt_counter;
  localparam int NG = 8, NE = 20, NL = 4;
  localparam int NEV = NG * NE * NL;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr = 1'b0, rd = 1'b0;
  logic [7:0]       addr = '0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata, rdata_w;
  logic [NEV-1:0]   evt = '0;
  int               n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  lane_evt_counter dut (
    .clk(clk), .rst(rst), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_i(evt)
  );

  lane_evt_counter #(.CNT_W(8)) dut_w (
    .clk(clk), .rst(rst), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata_w), .evt_i(evt)
  );

  typedef struct packed {
    logic [3:0]  sg; logic [7:0] se; logic [3:0] sl;
    logic [3:0]  dg; logic [7:0] de; logic [3:0] dl;
    logic [15:0] n;  logic [15:0] ex;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{4'd6, 8'd0,  4'd0, 4'd6, 8'd0,  4'd0, 16'd5, 16'd5},  // R6 basic
    '{4'd7, 8'd19, 4'd3, 4'd7, 8'd19, 4'd3, 16'd9, 16'd9},  // R6 last code, last lane
    '{4'd0, 8'd0,  4'd1, 4'd0, 8'd0,  4'd2, 16'd4, 16'd0},  // R6 other lane
    '{4'd3, 8'd5,  4'd2, 4'd3, 8'd6,  4'd2, 16'd4, 16'd0},  // R6 other event
    '{4'd2, 8'd5,  4'd2, 4'd3, 8'd5,  4'd2, 16'd4, 16'd0},  // R6 other group
    '{4'd1, 8'd1,  4'd4, 4'd1, 8'd1,  4'd0, 16'd3, 16'd0},  // R7 lane out of range
    '{4'd1, 8'd20, 4'd0, 4'd2, 8'd0,  4'd0, 16'd3, 16'd0},  // R7 event out of range
    '{4'd8, 8'd0,  4'd0, 4'd7, 8'd19, 4'd3, 16'd3, 16'd0},  // R7 group out of range
    '{4'd5, 8'd10, 4'd1, 4'd5, 8'd10, 4'd1, 16'd1, 16'd1}   // R6 single event
  };

  function automatic logic [31:0] cw(input logic [3:0] g, input logic [7:0] e,
                                     input logic [3:0] l, input logic [2:0] en,
                                     input logic [1:0] z);
    return {4'b0, g, e, 4'b0, l, 3'b0, en, z};
  endfunction

  function automatic int eidx(input int g, input int e, input int l);
    return (g * NE + e) * NL + l;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] v, output logic [31:0] vw);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    v = rdata; vw = rdata_w;
  endtask

  task automatic pulse(input int idx, input int n);
    evt[idx] = 1'b1;
    repeat (n) @(negedge clk);
    evt[idx] = 1'b0;
  endtask

  initial begin : watchdog
    #(4 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v, vw;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    reg_rd(8'h8, v, vw); chk("R1 ctrl after reset", v, 32'h0);
    reg_rd(8'hC, v, vw); chk("R1 count after reset", v, 32'h0);

    for (int i = 0; i < 9; i++) begin
      reg_wr(8'h8, cw(VEC[i].sg, VEC[i].se, VEC[i].sl, 3'd3, 2'd1));
      pulse(eidx(int'(VEC[i].dg), int'(VEC[i].de), int'(VEC[i].dl)), int'(VEC[i].n));
      reg_wr(8'h8, cw(VEC[i].sg, VEC[i].se, VEC[i].sl, 3'd1, 2'd0));
      reg_rd(8'hC, v, vw);
      chk($sformatf("R6/R7 vector %0d", i), v, 32'(VEC[i].ex));
    end

    // R2 field layout
    reg_wr(8'h8, cw(4'd7, 8'h13, 4'd2, 3'd0, 2'd0));
    reg_rd(8'h8, v, vw); chk("R2 readback", v, 32'h0713_0200);
    // R3 status bit
    reg_wr(8'h8, cw(4'd7, 8'h13, 4'd2, 3'd3, 2'd0));
    reg_rd(8'h8, v, vw); chk("R3 status on", v, 32'h0713_0280);
    reg_wr(8'h8, cw(4'd7, 8'h13, 4'd2, 3'd1, 2'd0));
    reg_rd(8'h8, v, vw); chk("R3 status off", v, 32'h0713_0200);
    // R4 ignored run commands
    reg_wr(8'h8, cw(4'd7, 8'h13, 4'd2, 3'd2, 2'd0));
    reg_rd(8'h8, v, vw); chk("R4 cmd 2 keeps off", v, 32'h0713_0200);
    reg_wr(8'h8, cw(4'd6, 8'd0, 4'd0, 3'd3, 2'd1));
    pulse(eidx(6, 0, 0), 3);
    reg_wr(8'h8, cw(4'd6, 8'd0, 4'd0, 3'd5, 2'd0));
    reg_rd(8'h8, v, vw); chk("R4 cmd 5 keeps on", v, 32'h0600_0080);
    pulse(eidx(6, 0, 0), 2);
    reg_wr(8'h8, cw(4'd6, 8'd0, 4'd0, 3'd1, 2'd0));
    reg_rd(8'hC, v, vw); chk("R4 counting continued", v, 32'd5);

    // R8 reselect keeps count
    reg_wr(8'h8, cw(4'd1, 8'd1, 4'd1, 3'd0, 2'd0));
    reg_rd(8'hC, v, vw); chk("R8 count kept on reselect", v, 32'd5);
    // R5 ignored zero codes, then zero
    reg_wr(8'h8, cw(4'd1, 8'd1, 4'd1, 3'd0, 2'd2));
    reg_rd(8'hC, v, vw); chk("R5 zero code 2 ignored", v, 32'd5);
    reg_wr(8'h8, cw(4'd1, 8'd1, 4'd1, 3'd0, 2'd3));
    reg_rd(8'hC, v, vw); chk("R5 zero code 3 ignored", v, 32'd5);
    reg_wr(8'h8, cw(4'd1, 8'd1, 4'd1, 3'd0, 2'd1));
    reg_rd(8'hC, v, vw); chk("R5 zero code 1", v, 32'd0);
    // R5 zero wins over a same-cycle event
    reg_wr(8'h8, cw(4'd6, 8'd0, 4'd0, 3'd3, 2'd1));
    evt[eidx(6, 0, 0)] = 1'b1;
    repeat (4) @(negedge clk);
    reg_wr(8'h8, cw(4'd6, 8'd0, 4'd0, 3'd0, 2'd1));
    evt[eidx(6, 0, 0)] = 1'b0;
    reg_wr(8'h8, cw(4'd6, 8'd0, 4'd0, 3'd1, 2'd0));
    reg_rd(8'hC, v, vw); chk("R5 zero beats event", v, 32'd0);

    // R11 read timing
    reg_wr(8'h8, cw(4'd6, 8'd0, 4'd0, 3'd3, 2'd1));
    evt[eidx(6, 0, 0)] = 1'b1;
    reg_rd(8'hC, v, vw); chk("R11 first read", v, 32'd0);
    reg_rd(8'hC, v, vw); chk("R11 second read", v, 32'd1);
    evt[eidx(6, 0, 0)] = 1'b0;
    reg_wr(8'h8, cw(4'd6, 8'd0, 4'd0, 3'd1, 2'd0));

    // R9 wrap on the 8-bit instance
    reg_wr(8'h8, cw(4'd6, 8'd0, 4'd0, 3'd3, 2'd1));
    pulse(eidx(6, 0, 0), 259);
    reg_wr(8'h8, cw(4'd6, 8'd0, 4'd0, 3'd1, 2'd0));
    reg_rd(8'hC, v, vw);
    chk("R9 wide count", v, 32'd259);
    chk("R9 narrow count wraps", vw, 32'd3);

    // R10 read-only data and unused offsets
    reg_wr(8'hC, 32'hDEAD_BEEF);
    reg_rd(8'hC, v, vw); chk("R10 data write ignored", v, 32'd259);
    reg_rd(8'h4, v, vw); chk("R10 other offset reads 0", v, 32'h0);
    reg_rd(8'hC, v, vw);
    reg_rd(8'h10, v, vw); chk("R10 offset 0x10 reads 0", v, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule